// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Link

This block carries single data words from a slave-side clock domain to a master-side clock domain using non-return-to-zero signalling. Each transfer costs exactly one edge on the request wire and one edge on the acknowledge wire, and either edge may be rising or falling. The two sides share no clock. Each side passes the incoming control wire through its own synchronizer chain. Each side also keeps the last level it acted on, so it reacts to a change of level rather than to the level itself.

On the master side a user pulses `start` while `ready` is high. The master flips `link_req`. The slave sees the flip after its synchronizer, clears the bus, reads one word from its source through `src_rd`/`src_data`, and puts the word on `link_data`. On the following cycle it flips `link_ack`. When the synchronized acknowledge level again matches the master's request level, the master latches the bus into `rdata` and pulses `done`. The bus is held stable from one cycle before the acknowledge edge until the next request edge, so it needs no synchronizer.

Top module: `tgl_link`

## Requirements
- R1: While their resets are asserted, `link_req`, `link_ack`, `done` and `link_data` are all 0 and `ready` is 1.
- R2: A `start` sampled high on a `clk_m` edge while `ready` is high inverts `link_req` at that edge, whatever its previous level.
- R3: A `start` sampled while `ready` is low is ignored: `link_req` keeps its level.
- R4: `ready` is low whenever `link_req` differs from the synchronized acknowledge level, so it falls one `clk_m` edge after an accepted `start`.
- R5: Each request edge causes exactly one single-cycle `src_rd` pulse. During that pulse `link_data` reads 0, because the previous word has been dropped.
- R6: The `src_data` word sampled at the end of the `src_rd` cycle appears on `link_data` at that `clk_s` edge. `link_ack` keeps its level through that edge and inverts on the next `clk_s` edge.
- R7: For each acknowledge edge, `done` is high for exactly one `clk_m` cycle, and `rdata` then holds the word the source supplied. Words arrive in source order, with none lost or repeated.
- R8: Transfers are correct and complete whether `clk_s` is faster or slower than `clk_m`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master-side clock |
| rst_m_n | input | 1 | Master-side reset, active low |
| start | input | 1 | Request one word; honoured only while ready is high |
| ready | output | 1 | No transfer outstanding |
| done | output | 1 | One-cycle pulse when rdata has been loaded |
| rdata | output | DATA_W | Last word received |
| clk_s | input | 1 | Slave-side clock |
| rst_s_n | input | 1 | Slave-side reset, active low |
| src_rd | output | 1 | One-cycle read strobe to the slave's data source |
| src_data | input | DATA_W | Word from the source, sampled at the end of the src_rd cycle |
| link_req | output | 1 | Request wire, master to slave (observation) |
| link_ack | output | 1 | Acknowledge wire, slave to master (observation) |
| link_data | output | DATA_W | Data wire, slave to master (observation) |

## Verification
The `link_req` flip is due one `clk_m` edge after `start` is accepted, and `ready` falls on that same edge. A `start` held one further cycle must leave the wire alone. On the slave side, `link_data` must be 0 while `src_rd` is high. The fetched word must be on the bus after the next `clk_s` edge with the acknowledge unchanged, and the acknowledge must flip one edge after that. Every sample is taken on the falling edge of the clock concerned. A scoreboard queue, filled at each fetch, is compared against every `done` pulse in order while the slave clock period is switched between faster-than-master and slower-than-master settings.

// File: rtl/tgl_pkg.sv
package tgl_pkg;

    localparam int DEF_DATA_W      = 32;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SLV_IDLE  = 2'd0,
        SLV_FETCH = 2'd1,
        SLV_ACK   = 2'd2
    } slv_state_e;

endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = d;
        end else begin : g_chain
            assign chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tgl_master.sv
module tgl_master #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] bus_data,
    output logic              req,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              req;
        logic              ack_seen;
        logic              done;
        logic [DATA_W-1:0] word;
    } mst_t;

    mst_t st_q, st_d;
    logic ack_moved;

    assign ready = (st_q.req == ack_s);

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.ack_seen = ack_s;
        ack_moved     = (ack_s != st_q.ack_seen);
        // completion: the acknowledge level has just caught up with the request level
        if (ack_moved && (ack_s == st_q.req)) begin
            st_d.done = 1'b1;
            st_d.word = bus_data;
        end
        if (start && ready) begin
            st_d.req = ~st_q.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req   = st_q.req;
    assign done  = st_q.done;
    assign rdata = st_q.word;
endmodule

// File: rtl/tgl_slave.sv
module tgl_slave
    import tgl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_rd,
    output logic              ack,
    output logic [DATA_W-1:0] bus_data
);
    typedef struct packed {
        slv_state_e        st;
        logic              req_seen;
        logic              ack;
        logic [DATA_W-1:0] word;
    } slv_t;

    slv_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        src_rd = 1'b0;
        unique case (st_q.st)
            SLV_IDLE: begin
                if (req_s != st_q.req_seen) begin
                    st_d.req_seen = req_s;
                    st_d.word     = '0;
                    st_d.st       = SLV_FETCH;
                end
            end
            SLV_FETCH: begin
                src_rd    = 1'b1;
                st_d.word = src_data;
                st_d.st   = SLV_ACK;
            end
            SLV_ACK: begin
                st_d.ack = ~st_q.ack;
                st_d.st  = SLV_IDLE;
            end
            default: st_d.st = SLV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack      = st_q.ack;
    assign bus_data = st_q.word;
endmodule

// File: rtl/tgl_link.sv
module tgl_link
    import tgl_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              start,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              clk_s,
    input  logic              rst_s_n,
    output logic              src_rd,
    input  logic [DATA_W-1:0] src_data,
    output logic              link_req,
    output logic              link_ack,
    output logic [DATA_W-1:0] link_data
);
    logic req_in_s;
    logic ack_in_m;

    tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk_s),
        .rst_n (rst_s_n),
        .d     (link_req),
        .q     (req_in_s)
    );

    tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk_m),
        .rst_n (rst_m_n),
        .d     (link_ack),
        .q     (ack_in_m)
    );

    tgl_master #(.DATA_W(DATA_W)) u_master (
        .clk      (clk_m),
        .rst_n    (rst_m_n),
        .start    (start),
        .ack_s    (ack_in_m),
        .bus_data (link_data),
        .req      (link_req),
        .ready    (ready),
        .done     (done),
        .rdata    (rdata)
    );

    tgl_slave #(.DATA_W(DATA_W)) u_slave (
        .clk      (clk_s),
        .rst_n    (rst_s_n),
        .req_s    (req_in_s),
        .src_data (src_data),
        .src_rd   (src_rd),
        .ack      (link_ack),
        .bus_data (link_data)
    );
endmodule

// File: rtl/tgl_link_chk.sv
module tgl_link_chk (
    input logic clk_m,
    input logic rst_m_n,
    input logic clk_s,
    input logic rst_s_n,
    input logic start,
    input logic ready,
    input logic done,
    input logic src_rd,
    input logic link_req,
    input logic link_ack
);
    // R1: wires are low after a reset cycle
    a_r1_req_reset: assert property (@(posedge clk_m) !rst_m_n |=> !link_req);
    a_r1_ack_reset: assert property (@(posedge clk_s) !rst_s_n |=> !link_ack);

    // R2: accepted start flips the request wire
    a_r2_req_flips: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        (start && ready) |=> (link_req != $past(link_req)));

    // R3: without an accepted start the request wire holds
    a_r3_req_holds: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        !(start && ready) |=> $stable(link_req));

    // R5: fetch strobe lasts one cycle
    a_r5_fetch_single: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        src_rd |=> !src_rd);

    // R6: acknowledge moves exactly two edges after a fetch cycle
    a_r6_ack_after_fetch: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        !$stable(link_ack) |-> $past(src_rd, 2));

    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        done |=> !done);
endmodule

bind tgl_link tgl_link_chk u_chk (
    .clk_m    (clk_m),
    .rst_m_n  (rst_m_n),
    .clk_s    (clk_s),
    .rst_s_n  (rst_s_n),
    .start    (start),
    .ready    (ready),
    .done     (done),
    .src_rd   (src_rd),
    .link_req (link_req),
    .link_ack (link_ack)
);

// File: tb/tgl_link_tb.sv
`timescale 1ns/1ps
module tgl_link_tb;
    localparam int DW = 32;

    logic          clk_m = 1'b0;
    logic          clk_s = 1'b0;
    logic          rst_m_n = 1'b0;
    logic          rst_s_n = 1'b0;
    logic          start = 1'b0;
    logic          ready, done, src_rd, link_req, link_ack;
    logic [DW-1:0] rdata, link_data;
    logic [DW-1:0] next_word = 32'h1234_5678;
    realtime       s_half = 1.85;

    int checks = 0;
    int failures = 0;
    int dones = 0;
    int fetches = 0;
    int issued = 0;
    bit finished = 0;
    logic [DW-1:0] exp_q[$];

    always #2.5 clk_m = ~clk_m;
    always #(s_half) clk_s = ~clk_s;

    tgl_link #(.DATA_W(DW)) u_dut (
        .clk_m     (clk_m),
        .rst_m_n   (rst_m_n),
        .start     (start),
        .ready     (ready),
        .done      (done),
        .rdata     (rdata),
        .clk_s     (clk_s),
        .rst_s_n   (rst_s_n),
        .src_rd    (src_rd),
        .src_data  (next_word),
        .link_req  (link_req),
        .link_ack  (link_ack),
        .link_data (link_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // master-side monitor: scoreboard compare on each completion
    always @(negedge clk_m) begin : mon_m
        logic [DW-1:0] w;
        if (rst_m_n && done) begin
            dones++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 completion with nothing pending", rdata, '0);
            end else begin
                w = exp_q.pop_front();
                chk(rdata == w, "R7 word order and value", rdata, w);
            end
        end
    end

    // slave-side monitor: fetch, bus and acknowledge timing
    int            s_cnt = 0;
    logic [DW-1:0] s_word;
    logic          s_ack;
    always @(negedge clk_s) begin
        if (rst_s_n) begin
            if (s_cnt == 1) begin
                chk(link_data == s_word, "R6 fetched word on bus", link_data, s_word);
                chk(link_ack == s_ack, "R6 ack held while data settles", {31'd0, link_ack}, {31'd0, s_ack});
                next_word = next_word * 32'h0019_660D + 32'h3C6E_F35F;
                s_cnt = 2;
            end else if (s_cnt == 2) begin
                chk(link_ack != s_ack, "R6 ack inverted", {31'd0, link_ack}, {31'd0, ~s_ack});
                s_cnt = 0;
            end
            if (src_rd) begin
                chk(s_cnt == 0, "R5 one fetch per request", s_cnt, 0);
                chk(link_data == '0, "R5 old word dropped", link_data, '0);
                s_word = next_word;
                s_ack  = link_ack;
                exp_q.push_back(next_word);
                fetches++;
                s_cnt = 1;
            end
        end
    end

    task automatic do_txn(input bit hold_extra);
        logic prev_req;
        do @(negedge clk_m); while (!ready);
        prev_req = link_req;
        start = 1'b1;
        issued++;
        @(negedge clk_m);
        chk(link_req == ~prev_req, "R2 request inverted", {31'd0, link_req}, {31'd0, ~prev_req});
        chk(!ready, "R4 ready low while outstanding", {31'd0, ready}, 0);
        if (hold_extra) begin
            @(negedge clk_m);
            chk(link_req == ~prev_req, "R3 start while busy ignored", {31'd0, link_req}, {31'd0, ~prev_req});
        end
        start = 1'b0;
    endtask

    task automatic run_phase(input realtime half, input int n, input string tag);
        int d0;
        s_half = half;
        d0 = dones;
        for (int i = 0; i < n; i++) do_txn((i % 4) == 1);
        for (int k = 0; k < 2000 && (dones - d0) < n; k++) @(negedge clk_m);
        chk((dones - d0) == n, tag, dones - d0, n);
    endtask

    initial begin
        repeat (4) @(negedge clk_m);
        chk(!link_req && !link_ack && !done && ready && link_data == '0,
            "R1 reset state", {link_req, link_ack, done, ready}, 4'b0001);
        rst_m_n = 1'b1;
        rst_s_n = 1'b1;
        repeat (3) @(negedge clk_m);
        run_phase(1.85, 30, "R8 all words with fast slave clock");
        run_phase(8.5,  30, "R8 all words with slow slave clock");
        run_phase(2.45, 30, "R8 all words with near-equal clocks");
        chk(fetches == issued, "R5 fetch count", fetches, issued);
        chk(exp_q.size() == 0, "R7 no word lost", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk_m);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule